// File: doc/BRIEF.md
# Two-Wire Setpoint Register Target

This block is a target on a two-wire serial bus (I2C) that keeps eight 10-bit setpoints, one per output channel, and presents all of them at once as a flat parallel vector. A bus master writes the setpoints, and can read them back, over the shared SCL and SDA lines. The block never drives SCL. It drives SDA only by pulling it low through an open-drain output enable.

A static mode input selects between two transfer styles. In streaming mode, one transfer carries all sixteen data bytes, two per channel, with channel 0 first. In indexed mode, a selector byte picks one channel, and exactly one byte pair moves. An indexed read writes the selector, issues a repeated START, and then reads the pair.

SCL and SDA are sampled by the system clock through two-stage synchronizers. START and STOP are recognised from edges of the synchronized lines. The device address is `1110 10x`, where the strap input supplies the lowest bit.

Top module: `i2c_setpoint_slave`

## Requirements
- R1: While reset is asserted and after it is released, every channel output is zero and `sda_oe` is 0.
- R2: The block acknowledges an address byte only when its upper seven bits equal `111010` followed by `addr_lsb`. For any other address it gives no acknowledge, drives nothing and writes nothing until the next START.
- R3: Every accepted byte, whether address, selector or data, is acknowledged by holding `sda_oe` at 1 through the ninth SCL high phase. Bytes are shifted MSB first.
- R4: In streaming mode (`block_mode`=1), a write of sixteen data bytes loads channels 0 to 7 in order. Byte 2k carries D9..D8 of channel k in bits [1:0], and its bits [7:2] are ignored. Byte 2k+1 carries D7..D0.
- R5: In streaming mode, a read returns the sixteen bytes in the same order and layout, with bits [7:2] of each upper byte reading as 0. A master NACK ends the read and releases SDA.
- R6: In indexed mode (`block_mode`=0), the first byte after a write address is a selector. Bits [2:0] give the channel and bits [7:3] are ignored. The two data bytes that follow load that channel.
- R7: In indexed mode, a read that follows a repeated START returns the upper byte and then the lower byte of the most recently selected channel.
- R8: A channel changes only when its second data byte is accepted. A transfer that stops after the first byte of a pair leaves the channel unchanged.
- R9: Data bytes beyond the sixteenth in streaming mode, or beyond the second in indexed mode, get no acknowledge and change nothing.
- R10: `sda_oe` changes only while SCL is low.
- R11: A repeated START at any point restarts address matching. A non-matching address after it gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_lsb | input | 1 | Strap for the lowest device address bit |
| block_mode | input | 1 | 1 selects streaming mode, 0 selects indexed mode |
| chan_val | output | 80 | Channel setpoints; channel k occupies bits [10k+9:10k] |

## Verification
Some properties are checked on every cycle by the assertions. The SDA enable may move only during an SCL low phase, apart from the release at START and STOP. A non-addressed or finished transfer never drives the bus. The shift counter stays within one byte plus the acknowledge slot. Channel storage changes only on a write strobe, and that strobe fires only during a write transfer.

Other behaviour can only be shown by the bench's bus scenarios. These include the byte layout and channel ordering, the readback ordering in both modes, and acknowledge versus no-acknowledge at each boundary. They also cover the repeated-START read path and the rule that a single orphan byte leaves a channel untouched.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2
  } link_st_e;

  localparam logic [5:0] DEV_ADDR_HI = 6'b111010;
endpackage

// File: rtl/sp_line_sync.sv
module sp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges only count as conditions while the clock stays high
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sp_chan_bank.sv
module sp_chan_bank #(
  parameter  int NCH = 8,
  parameter  int DW  = 10,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [CW-1:0]     rd_idx,
  output logic [DW-1:0]     rd_data,
  output logic [NCH*DW-1:0] vals
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             r <= '0;
      else if (wr_en && (wr_idx == CW'(c)))   r <= wr_data;
    end
    assign vals[c*DW +: DW] = r;
  end

  assign rd_data = vals[rd_idx*DW +: DW];

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vals)); // R8
endmodule

// File: rtl/i2c_setpoint_slave.sv
module i2c_setpoint_slave
  import sp_pkg::*;
#(
  parameter  int NCH = 8,
  parameter  int DW  = 10,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PW  = CW + 1,
  localparam int HW  = DW - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              addr_lsb,
  input  logic              block_mode,
  output logic [NCH*DW-1:0] chan_val
);
  localparam logic [PW-1:0] PTR_ONE  = PW'(1);
  localparam logic [PW-1:0] PTR_LAST = PW'(2*NCH-1);

  logic [1:0] rsync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_core_n = rsync[1];

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  sp_line_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  link_st_e      st_q, st_n;
  logic [3:0]    bitcnt_q, bitcnt_n;
  logic [7:0]    shreg_q, shreg_n;
  logic          oe_q, oe_n;
  logic          rd_q, rd_n;
  logic          first_q, first_n;
  logic          go_tx_q, go_tx_n;
  logic          mack_q, mack_n;
  logic          need_reg_q, need_reg_n;
  logic          full_q, full_n;
  logic [PW-1:0] ptr_q, ptr_n;
  logic [CW-1:0] sel_q, sel_n;
  logic [HW-1:0] hi_q, hi_n;

  logic          wr_en;
  logic [PW-1:0] load_ptr;
  logic [DW-1:0] rd_data;
  logic [7:0]    tx_byte;

  sp_chan_bank #(.NCH(NCH), .DW(DW)) i_bank (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en),
    .wr_idx(ptr_q[PW-1:1]), .wr_data({hi_q, shreg_q}),
    .rd_idx(load_ptr[PW-1:1]), .rd_data(rd_data), .vals(chan_val)
  );

  // pointer of the byte about to be loaded for transmission
  assign load_ptr = (st_q == ST_TX) ? ptr_q + PTR_ONE : ptr_q;

  always_comb begin
    tx_byte = '0;
    if (load_ptr[0]) tx_byte = rd_data[7:0];
    else             tx_byte[HW-1:0] = rd_data[DW-1:8];
  end

  always_comb begin
    st_n       = st_q;
    bitcnt_n   = bitcnt_q;
    shreg_n    = shreg_q;
    oe_n       = oe_q;
    rd_n       = rd_q;
    first_n    = first_q;
    go_tx_n    = go_tx_q;
    mack_n     = mack_q;
    need_reg_n = need_reg_q;
    full_n     = full_q;
    ptr_n      = ptr_q;
    sel_n      = sel_q;
    hi_n       = hi_q;
    wr_en      = 1'b0;
    if (bus_start) begin
      st_n     = ST_RX;
      bitcnt_n = 4'd0;
      first_n  = 1'b1;
      go_tx_n  = 1'b0;
      oe_n     = 1'b0;
    end else if (bus_stop) begin
      st_n    = ST_IDLE;
      go_tx_n = 1'b0;
      oe_n    = 1'b0;
    end else if (scl_rise) begin
      case (st_q)
        ST_RX: begin
          if (bitcnt_q == 4'd8) bitcnt_n = 4'd0;
          else begin
            shreg_n  = {shreg_q[6:0], sda_s};
            bitcnt_n = bitcnt_q + 4'd1;
          end
        end
        ST_TX: begin
          if (bitcnt_q == 4'd8) begin
            mack_n   = ~sda_s;
            bitcnt_n = 4'd0;
          end else bitcnt_n = bitcnt_q + 4'd1;
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st_q)
        ST_RX: begin
          if (bitcnt_q == 4'd8) begin
            if (first_q) begin
              if (shreg_q[7:1] == {DEV_ADDR_HI, addr_lsb}) begin
                oe_n       = 1'b1;
                first_n    = 1'b0;
                rd_n       = shreg_q[0];
                go_tx_n    = shreg_q[0];
                full_n     = 1'b0;
                need_reg_n = ~block_mode & ~shreg_q[0];
                ptr_n      = block_mode ? '0 : {sel_q, 1'b0};
              end else begin
                st_n = ST_IDLE;
              end
            end else if (need_reg_q) begin
              oe_n       = 1'b1;
              need_reg_n = 1'b0;
              sel_n      = shreg_q[CW-1:0];
              ptr_n      = {shreg_q[CW-1:0], 1'b0};
            end else if (!full_q) begin
              oe_n  = 1'b1;
              ptr_n = ptr_q + PTR_ONE;
              if (!ptr_q[0]) hi_n = shreg_q[HW-1:0];
              else begin
                wr_en  = 1'b1;
                full_n = ~block_mode | (ptr_q == PTR_LAST);
              end
            end
          end else if (bitcnt_q == 4'd0) begin
            if (go_tx_q) begin
              st_n    = ST_TX;
              go_tx_n = 1'b0;
              shreg_n = tx_byte;
              oe_n    = ~tx_byte[7];
            end else oe_n = 1'b0;
          end
        end
        ST_TX: begin
          if (bitcnt_q == 4'd8) oe_n = 1'b0;
          else if (bitcnt_q == 4'd0) begin
            if (mack_q) begin
              ptr_n   = load_ptr;
              shreg_n = tx_byte;
              oe_n    = ~tx_byte[7];
            end else begin
              st_n = ST_IDLE;
              oe_n = 1'b0;
            end
          end else begin
            shreg_n = {shreg_q[6:0], 1'b0};
            oe_n    = ~shreg_q[6];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q       <= ST_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      oe_q       <= 1'b0;
      rd_q       <= 1'b0;
      first_q    <= 1'b0;
      go_tx_q    <= 1'b0;
      mack_q     <= 1'b0;
      need_reg_q <= 1'b0;
      full_q     <= 1'b0;
      ptr_q      <= '0;
      sel_q      <= '0;
      hi_q       <= '0;
    end else begin
      st_q       <= st_n;
      bitcnt_q   <= bitcnt_n;
      shreg_q    <= shreg_n;
      oe_q       <= oe_n;
      rd_q       <= rd_n;
      first_q    <= first_n;
      go_tx_q    <= go_tx_n;
      mack_q     <= mack_n;
      need_reg_q <= need_reg_n;
      full_q     <= full_n;
      ptr_q      <= ptr_n;
      sel_q      <= sel_n;
      hi_q       <= hi_n;
    end
  end

  assign sda_oe = oe_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((oe_q != $past(oe_q)) && !$past(bus_start) && !$past(bus_stop)) |-> !$past(scl_s)); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_IDLE) |-> !oe_q); // R2
  AST_BIT_FRAME: assert property (@(posedge clk) disable iff (!rst_core_n)
    bitcnt_q <= 4'd8); // R3
  AST_WRITE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en |-> (st_q == ST_RX) && !rd_q && !first_q); // R4
  AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_TX) |-> rd_q); // R5
endmodule

// File: tb/test_i2c_setpoint_slave.sv
`timescale 1ns/1ps
module test_i2c_setpoint_slave;
  localparam int NCH = 8;
  localparam int DW  = 10;
  localparam int Q   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_lsb = 1'b0, block_mode = 1'b1;
  logic sda_oe;
  logic [NCH*DW-1:0] chan_val;
  wire  sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_setpoint_slave i_i2c_setpoint_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .addr_lsb(addr_lsb), .block_mode(block_mode),
    .chan_val(chan_val)
  );

  int n_chk = 0, n_bad = 0, viol = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NCH];
  logic [7:0] exp_q [$];
  logic [7:0] got_byte;
  string cur_tag = "";
  event byte_ev;
  logic prev_oe = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: pops one expected byte per received byte
  initial forever begin
    @(byte_ev);
    if (exp_q.size() == 0) chk({cur_tag, " unexpected byte"}, {24'd0, got_byte}, 32'hFFFF_FFFF);
    else chk(cur_tag, {24'd0, got_byte}, {24'd0, exp_q.pop_front()});
  end

  // R10 monitor: enable may move only while SCL is low
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
    prev_oe <= sda_oe;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_line;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rd_byte(input logic ack_it, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    wq();
    sda_m = ack_it ? 1'b0 : 1'b1;
    wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
    got_byte = b;
    -> byte_ev;
  endtask

  task automatic chk_all(input string tag);
    for (int c = 0; c < NCH; c++) chk(tag, {22'd0, chan_val[c*DW +: DW]}, {22'd0, model[c]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [DW-1:0] v;
    for (int c = 0; c < NCH; c++) model[c] = '0;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_all("R1 zero after reset");
    chk("R1 oe after reset", {31'd0, sda_oe}, 32'd0);

    // streaming write of all channels, junk in upper byte bits
    bus_start();
    wr_byte(8'hE8, ack); chk("R3 addr ack", {31'd0, ack}, 32'd1);
    for (int c = 0; c < NCH; c++) begin
      v = DW'((c * 131 + 7) & 10'h3FF);
      wr_byte({6'b101011, v[9:8]}, ack); chk("R3 hi ack", {31'd0, ack}, 32'd1);
      wr_byte(v[7:0], ack);               chk("R3 lo ack", {31'd0, ack}, 32'd1);
      model[c] = v;
    end
    bus_stop();
    chk_all("R4 streaming write");

    // streaming readback
    cur_tag = "R5 streaming read";
    bus_start();
    wr_byte(8'hE9, ack); chk("R5 read addr ack", {31'd0, ack}, 32'd1);
    for (int c = 0; c < NCH; c++) begin
      exp_q.push_back({6'd0, model[c][9:8]});
      exp_q.push_back(model[c][7:0]);
    end
    for (int k = 0; k < 2*NCH; k++) rd_byte(k != 2*NCH-1, b);
    bus_stop();
    chk("R5 released after nack", {31'd0, sda_oe}, 32'd0);

    // foreign address ignored
    bus_start();
    wr_byte(8'hEA, ack); chk("R2 foreign addr nack", {31'd0, ack}, 32'd0);
    wr_byte(8'h03, ack); chk("R2 ignored byte", {31'd0, ack}, 32'd0);
    wr_byte(8'h55, ack); chk("R2 ignored byte", {31'd0, ack}, 32'd0);
    bus_stop();
    chk_all("R2 no change");

    // 17 bytes: last one refused
    bus_start();
    wr_byte(8'hE8, ack);
    for (int c = 0; c < NCH; c++) begin
      v = DW'((1023 - c * 97) & 10'h3FF);
      wr_byte({6'b110101, v[9:8]}, ack);
      wr_byte(v[7:0], ack);
      model[c] = v;
    end
    chk("R9 last pair ack", {31'd0, ack}, 32'd1);
    wr_byte(8'hFF, ack); chk("R9 extra byte nack", {31'd0, ack}, 32'd0);
    bus_stop();
    chk_all("R9 extra discarded");

    // indexed write, channel 5 via selector with junk upper bits
    block_mode = 1'b0;
    wq();
    bus_start();
    wr_byte(8'hE8, ack);
    wr_byte(8'hF5, ack); chk("R6 selector ack", {31'd0, ack}, 32'd1);
    wr_byte(8'hFE, ack);
    wr_byte(8'h3C, ack); chk("R6 data ack", {31'd0, ack}, 32'd1);
    model[5] = 10'h23C;
    wr_byte(8'h11, ack); chk("R9 third byte nack", {31'd0, ack}, 32'd0);
    bus_stop();
    chk_all("R6 indexed write");

    // indexed read of channel 5 via repeated START
    cur_tag = "R7 indexed read";
    bus_start();
    wr_byte(8'hE8, ack);
    wr_byte(8'h9D, ack);
    bus_start();
    wr_byte(8'hE9, ack); chk("R11 restart read addr ack", {31'd0, ack}, 32'd1);
    exp_q.push_back({6'd0, model[5][9:8]});
    exp_q.push_back(model[5][7:0]);
    rd_byte(1'b1, b);
    rd_byte(1'b0, b);
    bus_stop();

    // orphan first byte
    bus_start();
    wr_byte(8'hE8, ack);
    wr_byte(8'h02, ack);
    wr_byte(8'h01, ack); chk("R8 first byte ack", {31'd0, ack}, 32'd1);
    bus_stop();
    chk("R8 channel 2 unchanged", {22'd0, chan_val[2*DW +: DW]}, {22'd0, model[2]});

    // repeated START to a foreign address
    bus_start();
    wr_byte(8'hE8, ack);
    wr_byte(8'h03, ack);
    bus_start();
    wr_byte(8'hEC, ack); chk("R11 foreign after restart", {31'd0, ack}, 32'd0);
    wr_byte(8'h02, ack); chk("R11 ignored byte", {31'd0, ack}, 32'd0);
    wr_byte(8'h00, ack);
    bus_stop();
    chk_all("R11 no change");

    // strap high
    addr_lsb = 1'b1;
    wq();
    bus_start();
    wr_byte(8'hE8, ack); chk("R2 old addr nack", {31'd0, ack}, 32'd0);
    bus_stop();
    bus_start();
    wr_byte(8'hEA, ack); chk("R2 strapped addr ack", {31'd0, ack}, 32'd1);
    wr_byte(8'h07, ack);
    wr_byte(8'h02, ack);
    wr_byte(8'hA5, ack);
    model[7] = 10'h2A5;
    bus_stop();
    chk_all("R2 strapped write");

    chk("R10 enable moved with SCL high", viol, 0);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule